// File: doc/BRIEF.md
# Serial Configuration Register Bank for a Sensor Front End

This block is the digital control side of an analog front end for an image sensor. A host writes settings over a three-wire serial link made of a serial clock, an active-low frame enable and a data line. Each write is one frame of a 3-bit register address followed by a 10-bit value. When the enable returns high after a well-formed frame, the value goes into one of five settings registers. These are an 8-bit auxiliary converter code, a 4-bit soft-clip code, a 9-bit gain code, a 4-bit power-down mask and a 10-bit clamp reference code. Their contents drive parallel outputs to the analog blocks. Each register also gives a one-cycle write strobe.

The three serial lines are asynchronous to the block clock. They are oversampled through synchronizers, and only the edges seen after synchronization count. The block clock must run at least four times faster than the serial clock.

The block also carries the converter's output word to the pins. The word stream is a valid-only stream with no ready signal. The block accepts one word on every cycle in which `pix_valid` is high and presents it one cycle later, so it applies no back-pressure. A global standby input forces every bit of the presented word to zero. An active-low output enable tells the pad ring whether to drive the data pins or leave them at high impedance.

Top module: `afe_cfg_regbank`

## Requirements
- R1: After reset, the auxiliary, gain, clamp and power-down registers read 0, the soft-clip register reads 15, and no write strobe is high.
- R2: A frame is sent most significant bit first: address bit 2, bit 1 and bit 0, then data bit 9 down to data bit 0. Each bit is sampled on a rising edge of `sclk`.
- R3: Rising edges of `sclk` while `sen_n` is high shift nothing and do not count toward a frame.
- R4: A register is written only at the rising edge of `sen_n`, and only if exactly 13 `sclk` rising edges arrived while `sen_n` was low. A frame of any other length changes no register and raises no strobe.
- R5: Address 0 loads `aux_code` from data bits 7..0. Address 2 loads `gain_code` from data bits 8..0. Address 4 loads `clamp_code` from all ten data bits.
- R6: Address 1 loads `clip_code` from data bits 3..0, and address 3 loads `pdn_mask` from data bits 3..0. Data bits 9..4 are ignored for both. In `pdn_mask`, bit 0 powers down the sampling, gain and clip chain, bit 1 the black clamp and blanking stage, bit 2 the auxiliary converter and bit 3 the fixed-gain output amplifier.
- R7: Addresses 5, 6 and 7 change no register and raise no strobe.
- R8: `wr_stb` bit n, where n is the register address (0 to 4), goes high for exactly one cycle. This is the cycle in which register n takes its new value. At most one strobe bit is high at any time. A register never changes while its strobe is low.
- R9: If `standby` is high in a cycle, `out_data` in the following cycle is all zeros.
- R10: `out_drive` is high exactly when `oe_n` is low, combinationally.
- R11: `out_valid` equals `pix_valid` delayed by one cycle. When `standby` is low, `out_data` equals `pix_data` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sen_n | input | 1 | Active-low frame enable, asynchronous |
| sdata | input | 1 | Serial data, asynchronous |
| standby | input | 1 | Global standby, forces the output word to zero |
| oe_n | input | 1 | Active-low output enable for the data pins |
| pix_valid | input | 1 | Converter word valid |
| pix_data | input | 10 | Converter word |
| out_valid | output | 1 | Presented word valid |
| out_data | output | 10 | Presented word, zero in standby |
| out_drive | output | 1 | Pad drive enable, low means high impedance |
| aux_code | output | 8 | Auxiliary converter code |
| clip_code | output | 4 | Soft-clip code |
| gain_code | output | 9 | Gain code |
| pdn_mask | output | 4 | Per-block power-down mask |
| clamp_code | output | 10 | Clamp reference code |
| wr_stb | output | 5 | Write strobes, bit index equals register address |

## Verification
A wrong bit count or a shift during an idle enable moves the frame boundary. The next well-formed frame is then either discarded or written to the wrong register with a rotated value. Both show on the register outputs and on the strobe tally within a cycle of the enable's rising edge. A decode fault shows as a strobe on the wrong bit, or as an update to a register that should have kept its value, in the same cycle as the update. Faults in the output path appear one cycle after the input word.

// File: rtl/afe_cfg_pkg.sv
package afe_cfg_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 10;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam int NUM_REGS = 5;

  localparam int AUX_W   = 8;
  localparam int CLIP_W  = 4;
  localparam int GAIN_W  = 9;
  localparam int PDN_W   = 4;
  localparam int CLAMP_W = 10;

  localparam logic [CLIP_W-1:0] CLIP_RST = 4'hF;

  typedef enum logic [ADDR_W-1:0] {
    SEL_AUX   = 3'd0,
    SEL_CLIP  = 3'd1,
    SEL_GAIN  = 3'd2,
    SEL_PDN   = 3'd3,
    SEL_CLAMP = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/afe_sync_edge.sv
module afe_sync_edge #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){RST_VAL[g]}};
      else        pipe <= {pipe[STAGES-1:0], async_in[g]};
    end
    assign level[g] = pipe[STAGES-1];
    assign rise[g]  = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/afe_frame_rx.sv
module afe_frame_rx #(
  parameter int FRAME_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               sen_n_lvl,
  input  logic               sen_n_rise,
  input  logic               sdata_lvl,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] frame_bits
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sen_n_rise) begin
      bit_cnt <= '0;
    end else if (!sen_n_lvl && sclk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdata_lvl};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_ok   = sen_n_rise && (bit_cnt == CNT_GOOD);
  assign frame_bits = shreg;
endmodule

// File: rtl/afe_cfg_field.sv
module afe_cfg_field #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST;
      stb <= 1'b0;
    end else begin
      stb <= we;
      if (we) q <= wdata;
    end
  end
endmodule

// File: rtl/afe_pix_out.sv
module afe_pix_out #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_valid,
  input  logic [W-1:0] pix_data,
  input  logic         standby,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pix_valid;
      out_data  <= standby ? '0 : pix_data;
    end
  end
endmodule

// File: rtl/afe_cfg_regbank.sv
module afe_cfg_regbank
  import afe_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sen_n,
  input  logic               sdata,
  input  logic               standby,
  input  logic               oe_n,
  input  logic               pix_valid,
  input  logic [PIX_W-1:0]   pix_data,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_data,
  output logic               out_drive,
  output logic [AUX_W-1:0]   aux_code,
  output logic [CLIP_W-1:0]  clip_code,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [PDN_W-1:0]   pdn_mask,
  output logic [CLAMP_W-1:0] clamp_code,
  output logic [NUM_REGS-1:0] wr_stb
);
  // bit 0 sclk, bit 1 sen_n, bit 2 sdata; enable idles high
  logic [2:0] sync_lvl, sync_rise;
  logic       frame_ok;
  logic [FRAME_W-1:0] frame_bits;
  logic [ADDR_W-1:0]  frame_addr;
  logic [DATA_W-1:0]  frame_data;
  logic [NUM_REGS-1:0] we;

  afe_sync_edge #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sdata, sen_n, sclk}),
    .level    (sync_lvl),
    .rise     (sync_rise)
  );

  afe_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sync_rise[0]),
    .sen_n_lvl  (sync_lvl[1]),
    .sen_n_rise (sync_rise[1]),
    .sdata_lvl  (sync_lvl[2]),
    .frame_ok   (frame_ok),
    .frame_bits (frame_bits)
  );

  assign frame_addr = frame_bits[FRAME_W-1:DATA_W];
  assign frame_data = frame_bits[DATA_W-1:0];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      we[i] = frame_ok && (frame_addr == ADDR_W'(i));
  end

  afe_cfg_field #(.W(AUX_W), .RST('0)) u_aux (
    .clk(clk), .rst_n(rst_n), .we(we[SEL_AUX]),
    .wdata(frame_data[AUX_W-1:0]), .q(aux_code), .stb(wr_stb[SEL_AUX]));

  afe_cfg_field #(.W(CLIP_W), .RST(CLIP_RST)) u_clip (
    .clk(clk), .rst_n(rst_n), .we(we[SEL_CLIP]),
    .wdata(frame_data[CLIP_W-1:0]), .q(clip_code), .stb(wr_stb[SEL_CLIP]));

  afe_cfg_field #(.W(GAIN_W), .RST('0)) u_gain (
    .clk(clk), .rst_n(rst_n), .we(we[SEL_GAIN]),
    .wdata(frame_data[GAIN_W-1:0]), .q(gain_code), .stb(wr_stb[SEL_GAIN]));

  afe_cfg_field #(.W(PDN_W), .RST('0)) u_pdn (
    .clk(clk), .rst_n(rst_n), .we(we[SEL_PDN]),
    .wdata(frame_data[PDN_W-1:0]), .q(pdn_mask), .stb(wr_stb[SEL_PDN]));

  afe_cfg_field #(.W(CLAMP_W), .RST('0)) u_clamp (
    .clk(clk), .rst_n(rst_n), .we(we[SEL_CLAMP]),
    .wdata(frame_data[CLAMP_W-1:0]), .q(clamp_code), .stb(wr_stb[SEL_CLAMP]));

  afe_pix_out #(.W(PIX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .standby   (standby),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign out_drive = ~oe_n;
endmodule

// File: rtl/afe_cfg_checker.sv
module afe_cfg_checker
  import afe_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIX_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               standby,
  input logic               pix_valid,
  input logic               out_valid,
  input logic [PIX_W-1:0]   out_data,
  input logic [AUX_W-1:0]   aux_code,
  input logic [CLIP_W-1:0]  clip_code,
  input logic [GAIN_W-1:0]  gain_code,
  input logic [PDN_W-1:0]   pdn_mask,
  input logic [CLAMP_W-1:0] clamp_code,
  input logic [NUM_REGS-1:0] wr_stb
);
  a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |=> !(|wr_stb));
  a_r5_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[0] |-> $stable(aux_code));
  a_r6_clip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[1] |-> $stable(clip_code));
  a_r5_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[2] |-> $stable(gain_code));
  a_r6_pdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[3] |-> $stable(pdn_mask));
  a_r5_clamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[4] |-> $stable(clamp_code));
  a_r9_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (out_data == '0));
  a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  a_r11_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
endmodule

bind afe_cfg_regbank afe_cfg_checker #(.SYNC_STAGES(SYNC_STAGES), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/test_afe_cfg_regbank.sv
module test_afe_cfg_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sen_n = 1'b1, sdata = 1'b0;
  logic standby = 1'b0, oe_n = 1'b1, pix_valid = 1'b0;
  logic [9:0] pix_data = '0;
  logic out_valid, out_drive;
  logic [9:0] out_data;
  logic [7:0] aux_code;
  logic [3:0] clip_code;
  logic [8:0] gain_code;
  logic [3:0] pdn_mask;
  logic [9:0] clamp_code;
  logic [4:0] wr_stb;

  int checks = 0, errors = 0;
  bit done = 0;
  int stb_seen [5];
  int stb_exp [5];
  int e_aux = 0, e_clip = 15, e_gain = 0, e_pdn = 0, e_clamp = 0;

  always #5 clk = ~clk;

  afe_cfg_regbank i_afe_cfg_regbank (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdata(sdata),
    .standby(standby), .oe_n(oe_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .out_valid(out_valid), .out_data(out_data), .out_drive(out_drive),
    .aux_code(aux_code), .clip_code(clip_code), .gain_code(gain_code),
    .pdn_mask(pdn_mask), .clamp_code(clamp_code), .wr_stb(wr_stb));

  always @(negedge clk) begin
    if (rst_n) for (int i = 0; i < 5; i++) stb_seen[i] += int'(wr_stb[i]);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, "aux_code", int'(aux_code), e_aux);
    chk(req, "clip_code", int'(clip_code), e_clip);
    chk(req, "gain_code", int'(gain_code), e_gain);
    chk(req, "pdn_mask", int'(pdn_mask), e_pdn);
    chk(req, "clamp_code", int'(clamp_code), e_clamp);
    for (int i = 0; i < 5; i++) chk(req, $sformatf("strobe count %0d", i), stb_seen[i], stb_exp[i]);
  endtask

  // expected register update from the requirements
  function automatic void model(input int a, input int d, input int nbits);
    if (nbits != 13) return;   // R4 wrong length discarded
    case (a)
      0: e_aux   = d & 8'hFF;  // R5
      1: e_clip  = d & 4'hF;   // R6
      2: e_gain  = d & 9'h1FF; // R5
      3: e_pdn   = d & 4'hF;   // R6
      4: e_clamp = d & 10'h3FF;// R5
      default: return;         // R7
    endcase
    stb_exp[a]++;
  endfunction

  task automatic sclk_pulse();
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input int a, input int d, input int nbits);
    logic [12:0] f;
    f = {3'(a), 10'(d)};
    sen_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 13) ? f[12-i] : 1'b1;
      sclk_pulse();
    end
    repeat (3) @(negedge clk);
    sen_n = 1'b1;
    repeat (10) @(negedge clk);
    model(a, d, nbits);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] prev_data;
    logic prev_valid, prev_sb;
    void'($urandom(32'd7321));
    for (int i = 0; i < 5; i++) begin stb_seen[i] = 0; stb_exp[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_regs("R1");
    chk("R1", "wr_stb", int'(wr_stb), 0);

    // R2 bit order: asymmetric patterns
    send(4, 10'h201, 13); check_regs("R2");
    send(2, 10'h155, 13); check_regs("R2");
    send(0, 10'h3C3, 13); check_regs("R5");
    // R6 upper bits ignored
    send(1, 10'h3FA, 13); check_regs("R6");
    send(3, 10'h3F5, 13); check_regs("R6");
    // R7 unused addresses
    send(5, 10'h3FF, 13); check_regs("R7");
    send(6, 10'h2AA, 13); check_regs("R7");
    send(7, 10'h155, 13); check_regs("R7");
    // R4 wrong lengths
    send(4, 10'h0F0, 12); check_regs("R4");
    send(4, 10'h0F0, 14); check_regs("R4");
    // R3 clock edges with enable idle must not count
    sdata = 1'b1;
    for (int i = 0; i < 5; i++) sclk_pulse();
    send(2, 10'h0AB, 13); check_regs("R3");

    // random mix
    for (int n = 0; n < 80; n++) begin
      int a, d, len, r;
      a = int'($urandom % 8);
      d = int'($urandom % 1024);
      r = int'($urandom % 10);
      len = (r == 0) ? 12 : (r == 1) ? 14 : 13;
      send(a, d, len);
      check_regs((len != 13) ? "R4" : (a > 4) ? "R7" : "R8");
    end
    // end of programming sequence: soft-clip reloaded with 15
    send(1, 15, 13); check_regs("R8");
    chk("R8", "clip after reload", int'(clip_code), 15);

    // output word path: R9, R10, R11
    prev_valid = 1'b0; prev_data = '0; prev_sb = 1'b0;
    for (int n = 0; n < 40; n++) begin
      pix_valid = 1'($urandom);
      pix_data  = 10'($urandom);
      standby   = (($urandom % 4) == 0);
      oe_n      = 1'($urandom);
      #1;
      chk("R10", "out_drive", int'(out_drive), int'(!oe_n));
      prev_valid = pix_valid; prev_data = pix_data; prev_sb = standby;
      @(negedge clk);
      chk("R11", "out_valid", int'(out_valid), int'(prev_valid));
      if (prev_sb) chk("R9", "out_data in standby", int'(out_data), 0);
      else         chk("R11", "out_data", int'(out_data), int'(prev_data));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule